// File: doc/BRIEF.md
# Two-Stage Bit-Clock Prescaler

This block derives the bit-rate enable for a serial audio port from the system clock. A 16-bit control word sets two things. An 8-bit modulus selects a programmable division by the modulus plus one. A range bit decides whether a fixed divide-by-eight stage runs ahead of the programmable stage or is bypassed. The output is a strobe that is high for one system-clock cycle. The serial logic downstream uses it as a clock enable, so the whole design stays in one clock domain.

Software writes and reads the control word through a synchronous port. An asynchronous active-low hardware reset and a synchronous software reset both clear the word. One setting is illegal: range bit set with a modulus of zero. For that setting the block defines its behaviour. It keeps the strobe low and raises an error flag that stays set until either reset.

When the modulus changes, the programmable counter takes the new value only at its next reload. The period that is already under way therefore completes with the old count.

Top module: `bclk_prescaler`

## Requirements
- R1: With the range bit (control bit 8) clear, `tick_o` repeats every (M+1)×8 system clocks, where M is the modulus in control bits 7:0.
- R2: With the range bit set and M of 1 or more, `tick_o` repeats every M+1 system clocks.
- R3: Hardware reset and software reset each clear the control word, so `rd_data` reads 0. The first `tick_o` then appears 8 clocks after the reset is removed.
- R4: `rd_data` returns the modulus in bits 7:0 and the range bit in bit 8. Bits 15:9 always read zero, whatever was written to them.
- R5: While the configuration is unchanged, `tick_o` is high for exactly one clock per period.
- R6: While the range bit is set and M is zero, `tick_o` stays low.
- R7: `cfg_err_o` rises on the clock after the illegal setting is written. It stays high after a legal setting is written, and only hardware reset or software reset clears it.
- R8: A modulus written in the middle of a period does not shorten that period. The new ratio applies from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| wr_en | input | 1 | Writes `wr_data` into the control word at the clock edge |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word, reserved bits read as zero |
| tick_o | output | 1 | One-cycle bit-clock enable strobe |
| cfg_err_o | output | 1 | Sticky flag set by the illegal setting |

## Verification
The assertions assume that `rst_n` is asserted before the first clock edge. They also assume that `soft_rst` and `wr_en` change only between clock edges.

The one-cycle spacing of the divide-by-eight stage is assumed only while the range bit is steady. The bench therefore measures every period only after at least two full periods have passed since the last write. The single check of the mid-period update is the only place where it writes the control word while the count is running.

// File: rtl/bclk_pkg.sv
`timescale 1ns/1ps
package bclk_pkg;
  localparam int unsigned DEF_REG_W  = 16;
  localparam int unsigned DEF_MOD_W  = 8;
  localparam int unsigned DEF_OCT_LG = 3;

  // Illegal setting: bypass of the fixed stage with a zero modulus.
  function automatic logic setting_illegal(logic bypass, int unsigned modulus);
    return bypass && (modulus == 0);
  endfunction
endpackage

// File: rtl/bclk_cfg_reg.sv
`timescale 1ns/1ps
module bclk_cfg_reg #(
  parameter int unsigned REG_W = bclk_pkg::DEF_REG_W,
  parameter int unsigned MOD_W = bclk_pkg::DEF_MOD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [MOD_W-1:0] modulus,
  output logic             bypass
);
  localparam int unsigned RSV_LO = MOD_W + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modulus <= '0;
      bypass  <= 1'b0;
    end else if (soft_rst) begin
      modulus <= '0;
      bypass  <= 1'b0;
    end else if (wr_en) begin
      modulus <= wr_data[MOD_W-1:0];
      bypass  <= wr_data[MOD_W];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[MOD_W:0] = {bypass, modulus};
  end

  // R3
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data == '0));

  // R4
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[REG_W-1:RSV_LO] != '0)) |=> (rd_data[REG_W-1:RSV_LO] == '0));
endmodule

// File: rtl/bclk_oct_stage.sv
`timescale 1ns/1ps
module bclk_oct_stage #(
  parameter int unsigned OCT_LG = bclk_pkg::DEF_OCT_LG
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic bypass,
  output logic stage_en
);
  logic [OCT_LG-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase_q <= '0;
    else if (soft_rst || bypass) phase_q <= '0;
    else                         phase_q <= phase_q + 1'b1;
  end

  assign stage_en = bypass | (phase_q == '1);

  // R1
  oct_gap_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (!bypass && stage_en) |=> (!stage_en || bypass));
endmodule

// File: rtl/bclk_mod_counter.sv
`timescale 1ns/1ps
module bclk_mod_counter #(
  parameter int unsigned MOD_W = bclk_pkg::DEF_MOD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             stage_en,
  input  logic             bypass,
  input  logic [MOD_W-1:0] modulus,
  output logic             tick,
  output logic             err_flag,
  output logic             illegal_now,
  output logic             term_hit
);
  logic [MOD_W-1:0] cnt_q;

  function automatic logic [MOD_W-1:0] next_count(logic [MOD_W-1:0] cur,
                                                  logic [MOD_W-1:0] reload);
    return (cur == '0) ? reload : cur - 1'b1;
  endfunction

  assign illegal_now = bclk_pkg::setting_illegal(bypass, 32'(modulus));
  assign term_hit    = stage_en && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      tick     <= 1'b0;
      err_flag <= 1'b0;
    end else if (soft_rst) begin
      cnt_q    <= '0;
      tick     <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (stage_en) cnt_q <= next_count(cnt_q, modulus);
      tick     <= term_hit && !illegal_now;
      err_flag <= err_flag | illegal_now;
    end
  end

  // R6
  no_tick_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    tick |-> !$past(illegal_now));

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    illegal_now |=> err_flag);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    err_flag |=> err_flag);
endmodule

// File: rtl/bclk_prescaler.sv
`timescale 1ns/1ps
module bclk_prescaler #(
  parameter int unsigned REG_W  = bclk_pkg::DEF_REG_W,
  parameter int unsigned MOD_W  = bclk_pkg::DEF_MOD_W,
  parameter int unsigned OCT_LG = bclk_pkg::DEF_OCT_LG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick_o,
  output logic             cfg_err_o
);
  logic [MOD_W-1:0] modulus;
  logic             bypass;
  logic             stage_en;
  logic             illegal_now;
  logic             term_hit;

  bclk_cfg_reg #(.REG_W(REG_W), .MOD_W(MOD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .modulus(modulus), .bypass(bypass)
  );

  bclk_oct_stage #(.OCT_LG(OCT_LG)) u_oct (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bypass(bypass),
    .stage_en(stage_en)
  );

  bclk_mod_counter #(.MOD_W(MOD_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stage_en(stage_en),
    .bypass(bypass), .modulus(modulus), .tick(tick_o), .err_flag(cfg_err_o),
    .illegal_now(illegal_now), .term_hit(term_hit)
  );

  // R8
  reload_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    tick_o |-> $past(term_hit));
endmodule

// File: tb/bclk_prescaler_bench.sv
`timescale 1ns/1ps
module bclk_prescaler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 5000;
  localparam int NVEC       = 10;
  // each entry: {range bit, modulus}
  localparam logic [8:0] VEC [NVEC] = '{
    9'h000, 9'h001, 9'h005, 9'h0FF, 9'h080,
    9'h101, 9'h102, 9'h107, 9'h164, 9'h1FF
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        tick_o;
  logic        cfg_err_o;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bclk_prescaler u_bclk_prescaler (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick_o(tick_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int want_period(logic rng, int m);
    int base = m + 1;
    return rng ? base : base * 8;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic pulse_soft();
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic count_to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_o && n < TIMEOUT);
  endtask

  task automatic measure(output int n);
    int d;
    count_to_tick(d);
    count_to_tick(d);
    count_to_tick(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state and first tick
    check("R3 rd_data after hw reset", int'(rd_data), 0);
    check("R7 err clear after hw reset", int'(cfg_err_o), 0);
    count_to_tick(n);
    check("R3 first tick after hw reset", n, 8);

    // R1 R2 R5 sweep
    for (int i = 0; i < NVEC; i++) begin
      write_cfg({7'h00, VEC[i]});
      measure(n);
      check(VEC[i][8] ? "R2 period" : "R1 period", n,
            want_period(VEC[i][8], int'(VEC[i][7:0])));
      @(negedge clk);
      check("R5 single-cycle tick", int'(tick_o), 0);
    end

    // R4 reserved bits
    write_cfg(16'hFFFF);
    check("R4 readback", int'(rd_data), 16'h01FF);
    write_cfg(16'hA603);
    check("R4 readback mixed", int'(rd_data), 16'h0003);

    // R3 soft reset
    write_cfg(16'h0155);
    pulse_soft();
    check("R3 rd_data after soft reset", int'(rd_data), 0);
    count_to_tick(n);
    check("R3 first tick after soft reset", n, 8);

    // R6 R7 illegal setting
    write_cfg(16'h0100);
    hits = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (tick_o) hits++;
    end
    check("R6 ticks under illegal setting", hits, 0);
    check("R7 err raised", int'(cfg_err_o), 1);
    write_cfg(16'h0103);
    check("R7 err sticky after legal write", int'(cfg_err_o), 1);
    measure(n);
    check("R2 period after illegal", n, 4);
    check("R7 err still set", int'(cfg_err_o), 1);
    pulse_soft();
    check("R7 err cleared by soft reset", int'(cfg_err_o), 0);

    // R8 mid-period modulus change
    write_cfg(16'h01C8);
    measure(n);
    check("R2 period M=200", n, 201);
    write_cfg(16'h0103);
    count_to_tick(n);
    check("R8 old period completes", n, 199);
    count_to_tick(n);
    check("R8 new period after reload", n, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule